// File: doc/BRIEF.md
# Expansion Bus Channel Controller

This block is the register front end for a small set of serial expansion channels (three by default). Each channel owns five 32-bit registers: a status/control word, a DMA memory address, a DMA length, a transfer-control word and an immediate-data word. Software picks a device on a channel by setting chip-select bits in the status/control word. It then starts a transfer by writing the control word with its start bit set. The controller hands the request to the device side over a start/done handshake, and reports completion, device events and attach/detach changes as masked interrupt status. All pending interrupts of all channels merge into one CPU interrupt line.

A single sequencer serves all channels. It has three states. In IDLE it waits for a launch. It takes the LAUNCH transition when a control write carries the start bit on a channel with a device selected. LAUNCH is one cycle long, drives the start pulse and always moves on to WAIT. WAIT holds until the device reports done, then takes the COMPLETE transition back to IDLE. Moving data between memory and the device and driving the serial wires are handled outside this block.

Top module: `exp_bus_ctrl`

## Requirements
- R1: After reset every register of every channel reads zero, `cpu_irq` is low and `dev_start` is low.
- R2: The memory-address, length and data registers read back the last value written. A register address whose channel field (address bits 4:3) is 3 or more reads zero. The register field (bits 2:0) is 0 for status/control, 1 for address, 2 for length, 3 for control and 4 for data.
- R3: In the status/control word the status bits 1 (device), 3 (transfer done) and 11 (attach/detach) are cleared by writing 1 and kept by writing 0. Bit 12 (device present) is read-only. Every other bit takes the written value.
- R4: A status event in the same cycle as a write-one clear of that bit leaves the bit set.
- R5: `cpu_irq` is high exactly when some channel has a status bit set together with the mask bit just below it (mask bits 0, 2 and 10).
- R6: The device index comes from the chip-select bits 9:7 with priority bit 7 (index 0), then bit 8 (index 1), then bit 9 (index 2). A transfer presents that index on `dev_index`.
- R7: A control write with the start bit set (bit 0) while the channel has no chip select set launches nothing, and the start bit reads 0.
- R8: A control write with bit 0 set on a selected channel while IDLE raises `dev_start` for exactly one cycle, in the cycle after the write. With the pulse come the channel, the index, the direction (control bits 3:2), the DMA flag (bit 1) and `dev_bytes` = control bits 5:4 plus one. While the transfer is in flight the start bit reads 1.
- R9: When `dev_done` arrives in WAIT, the start bit clears and status bit 3 sets in the next cycle. If the direction was 00 and DMA was 0, the data register takes `dev_rdata`; otherwise the data register is left unchanged.
- R10: Every status/control write arms the channel's command-phase flag, shown on `dev_cmd_phase` during its transfers. Completing a non-DMA transfer with direction 01 disarms it.
- R11: An attach pulse sets bits 12 and 11. A detach pulse clears bit 12 and sets bit 11.
- R12: A control write with the start bit while a transfer is in flight launches nothing, and its start bit reads 0.
- R13: A device interrupt pulse on a channel sets its status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Write address {channel, register} |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 5 | Read address {channel, register} |
| reg_rdata | output | 32 | Read data (combinational) |
| ext_attach | input | 3 | Per-channel attach pulse |
| ext_detach | input | 3 | Per-channel detach pulse |
| ext_dev_irq | input | 3 | Per-channel device interrupt pulse |
| dev_start | output | 1 | One-cycle transfer start |
| dev_chan | output | 2 | Channel of the transfer |
| dev_index | output | 2 | Selected device index |
| dev_dir | output | 2 | Direction field |
| dev_dma | output | 1 | DMA-mode flag |
| dev_bytes | output | 3 | Byte count, 1 to 4 |
| dev_cmd_phase | output | 1 | Command-phase flag of the active channel |
| dev_done | input | 1 | Device finished the transfer |
| dev_rdata | input | 32 | Immediate read data from the device |
| cpu_irq | output | 1 | Merged interrupt |

## Verification
Two things can happen to the same status bit in one cycle: software clears it by writing 1 to the status/control word, while a device event, attach, detach or transfer completion sets it. The bench causes this on purpose. It raises `dev_done` in the cycle of a write that clears bit 3, and it pulses attach in the cycle of a write that clears bit 11. During the random phase it also drives device interrupt pulses in the same cycles as the random status writes. In every case the bench reads the word back the next cycle and expects the bit set, and its reference model lets the set win when it predicts `cpu_irq`.

// File: rtl/exb_pkg.sv
package exb_pkg;
    localparam logic [2:0] REG_CSR  = 3'd0;
    localparam logic [2:0] REG_MADR = 3'd1;
    localparam logic [2:0] REG_LEN  = 3'd2;
    localparam logic [2:0] REG_CTRL = 3'd3;
    localparam logic [2:0] REG_DATA = 3'd4;

    // status/control bit positions (status sits one above its mask)
    localparam int B_DEV_ST  = 1;
    localparam int B_TC_ST   = 3;
    localparam int B_CS_LO   = 7;
    localparam int B_EXT_ST  = 11;
    localparam int B_PRESENT = 12;

    localparam logic [31:0] ST_BITS = 32'h0000_080A;
    localparam logic [31:0] RO_BITS = 32'h0000_1000;

    localparam logic [1:0] SEL_NONE = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT
    } seq_state_e;
endpackage

// File: rtl/exb_chan.sv
module exb_chan
    import exb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_reg,
    input  logic [DW-1:0] wdata,
    input  logic          launch,
    input  logic          complete,
    input  logic          load_rd,
    input  logic          clr_cmd,
    input  logic [DW-1:0] rd_in,
    input  logic          attach,
    input  logic          detach,
    input  logic          dev_irq_in,
    output logic [DW-1:0] csr_q,
    output logic [DW-1:0] madr_q,
    output logic [DW-1:0] len_q,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] data_q,
    output logic [1:0]    sel_idx,
    output logic          first_imm,
    output logic          irq_pend
);
    logic [DW-1:0] csr_nxt;
    logic          csr_wr;

    assign csr_wr = wr_en && (wr_reg == REG_CSR);

    always_comb begin
        csr_nxt = csr_q;
        if (csr_wr) begin
            csr_nxt = (csr_q & ~wdata & ST_BITS) | (csr_q & RO_BITS)
                    | (wdata & ~(ST_BITS | RO_BITS));
        end
        if (dev_irq_in) csr_nxt[B_DEV_ST] = 1'b1;
        if (complete)   csr_nxt[B_TC_ST]  = 1'b1;
        if (detach) begin
            csr_nxt[B_PRESENT] = 1'b0;
            csr_nxt[B_EXT_ST]  = 1'b1;
        end
        if (attach) begin
            csr_nxt[B_PRESENT] = 1'b1;
            csr_nxt[B_EXT_ST]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q     <= '0;
            madr_q    <= '0;
            len_q     <= '0;
            ctrl_q    <= '0;
            data_q    <= '0;
            first_imm <= 1'b0;
        end else begin
            csr_q <= csr_nxt;
            if (wr_en && wr_reg == REG_MADR) madr_q <= wdata;
            if (wr_en && wr_reg == REG_LEN)  len_q  <= wdata;
            if (wr_en && wr_reg == REG_CTRL) ctrl_q <= {wdata[DW-1:1], launch};
            else if (complete)               ctrl_q[0] <= 1'b0;
            if (load_rd)                     data_q <= rd_in;
            else if (wr_en && wr_reg == REG_DATA) data_q <= wdata;
            if (csr_wr)       first_imm <= 1'b1;
            else if (clr_cmd) first_imm <= 1'b0;
        end
    end

    always_comb begin
        if (csr_q[B_CS_LO])          sel_idx = 2'd0;
        else if (csr_q[B_CS_LO + 1]) sel_idx = 2'd1;
        else if (csr_q[B_CS_LO + 2]) sel_idx = 2'd2;
        else                         sel_idx = SEL_NONE;
    end

    assign irq_pend = |(csr_q & (csr_q << 1) & ST_BITS);
endmodule

// File: rtl/exb_seq.sv
module exb_seq
    import exb_pkg::*;
#(
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_ctrl,
    input  logic [CHW-1:0] wr_chan,
    input  logic [5:0]     wr_fields,
    input  logic [1:0]     wr_sel,
    input  logic           dev_done,
    output logic           launch,
    output logic           complete,
    output logic           dev_start,
    output logic [CHW-1:0] cur_chan,
    output logic [1:0]     cur_idx,
    output logic           cur_dma,
    output logic [1:0]     cur_dir,
    output logic [1:0]     cur_len
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        launch   = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (wr_ctrl && wr_fields[0] && wr_sel != SEL_NONE) begin
                    launch  = 1'b1;
                    state_d = SQ_LAUNCH;
                end
            end
            SQ_LAUNCH: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (dev_done) begin
                    complete = 1'b1;
                    state_d  = SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            cur_chan <= '0;
            cur_idx  <= SEL_NONE;
            cur_dma  <= 1'b0;
            cur_dir  <= 2'd0;
            cur_len  <= 2'd0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                cur_chan <= wr_chan;
                cur_idx  <= wr_sel;
                cur_dma  <= wr_fields[1];
                cur_dir  <= wr_fields[3:2];
                cur_len  <= wr_fields[5:4];
            end
        end
    end

    always_comb begin
        dev_start = (state_q == SQ_LAUNCH);
    end
endmodule

// File: rtl/exp_bus_ctrl.sv
module exp_bus_ctrl
    import exb_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 32,
    localparam int CHW   = $clog2(NUM_CH),
    localparam int AW    = CHW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_waddr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [AW-1:0]     reg_raddr,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0] ext_attach,
    input  logic [NUM_CH-1:0] ext_detach,
    input  logic [NUM_CH-1:0] ext_dev_irq,
    output logic              dev_start,
    output logic [CHW-1:0]    dev_chan,
    output logic [1:0]        dev_index,
    output logic [1:0]        dev_dir,
    output logic              dev_dma,
    output logic [2:0]        dev_bytes,
    output logic              dev_cmd_phase,
    input  logic              dev_done,
    input  logic [DW-1:0]     dev_rdata,
    output logic              cpu_irq
);
    logic [NUM_CH-1:0][DW-1:0] csr_all, madr_all, len_all, ctrl_all, data_all;
    logic [NUM_CH-1:0][1:0]    sel_all;
    logic [NUM_CH-1:0]         fimm_all, pend_all, wr_ch, launch_ch, cmpl_ch, load_ch, clr_ch;
    logic [CHW-1:0]            wchan, rchan;
    logic [2:0]                wreg, rreg;
    logic                      launch, complete, wr_ctrl;
    logic [1:0]                wr_sel, cur_len;

    assign wchan   = reg_waddr[AW-1:3];
    assign wreg    = reg_waddr[2:0];
    assign rchan   = reg_raddr[AW-1:3];
    assign rreg    = reg_raddr[2:0];
    assign wr_ctrl = reg_wr && (wreg == REG_CTRL) && (int'(wchan) < NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign wr_ch[g]     = reg_wr && (wchan == CHW'(g));
        assign launch_ch[g] = launch && (wchan == CHW'(g));
        assign cmpl_ch[g]   = complete && (dev_chan == CHW'(g));
        assign load_ch[g]   = cmpl_ch[g] && (dev_dir == 2'b00) && !dev_dma;
        assign clr_ch[g]    = cmpl_ch[g] && (dev_dir == 2'b01) && !dev_dma;

        exb_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_ch[g]),
            .wr_reg    (wreg),
            .wdata     (reg_wdata),
            .launch    (launch_ch[g]),
            .complete  (cmpl_ch[g]),
            .load_rd   (load_ch[g]),
            .clr_cmd   (clr_ch[g]),
            .rd_in     (dev_rdata),
            .attach    (ext_attach[g]),
            .detach    (ext_detach[g]),
            .dev_irq_in(ext_dev_irq[g]),
            .csr_q     (csr_all[g]),
            .madr_q    (madr_all[g]),
            .len_q     (len_all[g]),
            .ctrl_q    (ctrl_all[g]),
            .data_q    (data_all[g]),
            .sel_idx   (sel_all[g]),
            .first_imm (fimm_all[g]),
            .irq_pend  (pend_all[g])
        );
    end

    always_comb begin
        wr_sel        = SEL_NONE;
        dev_cmd_phase = 1'b0;
        reg_rdata     = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wchan == CHW'(i))    wr_sel = sel_all[i];
            if (dev_chan == CHW'(i)) dev_cmd_phase = fimm_all[i];
            if (rchan == CHW'(i)) begin
                case (rreg)
                    REG_CSR:  reg_rdata = csr_all[i];
                    REG_MADR: reg_rdata = madr_all[i];
                    REG_LEN:  reg_rdata = len_all[i];
                    REG_CTRL: reg_rdata = ctrl_all[i];
                    REG_DATA: reg_rdata = data_all[i];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

    exb_seq #(.CHW(CHW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_chan  (wchan),
        .wr_fields(reg_wdata[5:0]),
        .wr_sel   (wr_sel),
        .dev_done (dev_done),
        .launch   (launch),
        .complete (complete),
        .dev_start(dev_start),
        .cur_chan (dev_chan),
        .cur_idx  (dev_index),
        .cur_dma  (dev_dma),
        .cur_dir  (dev_dir),
        .cur_len  (cur_len)
    );

    assign dev_bytes = {1'b0, cur_len} + 3'd1;
    assign cpu_irq   = |pend_all;
endmodule

// File: rtl/exb_checker.sv
module exb_checker #(
    parameter int NUM_CH = 3,
    parameter int DW     = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dev_start,
    input logic [1:0]                dev_index,
    input logic                      cpu_irq,
    input logic [NUM_CH-1:0]         ext_attach,
    input logic [NUM_CH-1:0]         ext_detach,
    input logic [NUM_CH-1:0]         cmpl_ch,
    input logic [NUM_CH-1:0][DW-1:0] csr_all,
    input logic [NUM_CH-1:0][DW-1:0] ctrl_all
);
    logic any_pend;
    always_comb begin
        any_pend = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if ((csr_all[i][1] && csr_all[i][0]) || (csr_all[i][3] && csr_all[i][2])
                || (csr_all[i][11] && csr_all[i][10]))
                any_pend = 1'b1;
        end
    end

    assert_irq_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == any_pend);

    assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_start |=> !dev_start);

    assert_index_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_start |-> dev_index != 2'd3);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_attach_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ext_attach[g] |=> csr_all[g][12] && csr_all[g][11]);

        assert_detach_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_detach[g] && !ext_attach[g]) |=> !csr_all[g][12] && csr_all[g][11]);

        assert_complete_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cmpl_ch[g] |=> csr_all[g][3] && !ctrl_all[g][0]);
    end
endmodule

bind exp_bus_ctrl exb_checker #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_start (dev_start),
    .dev_index (dev_index),
    .cpu_irq   (cpu_irq),
    .ext_attach(ext_attach),
    .ext_detach(ext_detach),
    .cmpl_ch   (cmpl_ch),
    .csr_all   (csr_all),
    .ctrl_all  (ctrl_all)
);

// File: tb/exp_bus_ctrl_tb.sv
module exp_bus_ctrl_tb;
    localparam logic [31:0] ST = 32'h0000_080A;
    localparam logic [31:0] RO = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  ext_attach = '0, ext_detach = '0, ext_dev_irq = '0;
    logic        dev_start, dev_dma, dev_cmd_phase, cpu_irq;
    logic [1:0]  dev_chan, dev_index, dev_dir;
    logic [2:0]  dev_bytes;
    logic        dev_done = 1'b0;
    logic [31:0] dev_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] csr_m [3];

    always #4 clk = ~clk;

    exp_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ext_attach(ext_attach), .ext_detach(ext_detach), .ext_dev_irq(ext_dev_irq),
        .dev_start(dev_start), .dev_chan(dev_chan), .dev_index(dev_index),
        .dev_dir(dev_dir), .dev_dma(dev_dma), .dev_bytes(dev_bytes),
        .dev_cmd_phase(dev_cmd_phase), .dev_done(dev_done), .dev_rdata(dev_rdata),
        .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] csr_after(input logic [31:0] cur, input logic [31:0] d);
        return (cur & ~d & ST) | (cur & RO) | (d & ~(ST | RO));
    endfunction

    function automatic logic irq_of(input logic [31:0] c);
        return |(c & (c << 1) & ST);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [2:0] rg, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = {2'(ch), rg}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [2:0] rg, output logic [31:0] v);
        reg_raddr = {2'(ch), rg};
        #1;
        v = reg_rdata;
    endtask

    // launch on a selected channel, check the pulse, then complete
    task automatic xfer(input int ch, input logic [31:0] c, input logic [31:0] rdat,
                        input logic [1:0] exp_idx, input logic exp_cmd, input string tag);
        logic [31:0] v;
        wr(ch, 3'd3, c);
        chk(dev_start === 1'b1, {tag, " R8 start"}, 32'(dev_start), 32'd1);
        chk(dev_index === exp_idx, {tag, " R6 index"}, 32'(dev_index), 32'(exp_idx));
        chk(dev_chan === 2'(ch) && dev_dir === c[3:2] && dev_dma === c[1] &&
            dev_bytes === 3'(c[5:4]) + 3'd1,
            {tag, " R8 fields"}, {dev_chan, dev_dir, dev_dma, dev_bytes}, {2'(ch), c[3:2], c[1], 3'(c[5:4]) + 3'd1});
        chk(dev_cmd_phase === exp_cmd, {tag, " R10 cmd phase"}, 32'(dev_cmd_phase), 32'(exp_cmd));
        rd(ch, 3'd3, v);
        chk(v[0] === 1'b1, {tag, " R8 busy start bit"}, v, 32'd1);
        @(negedge clk);
        chk(dev_start === 1'b0, {tag, " R8 single pulse"}, 32'(dev_start), 32'd0);
        dev_done = 1'b1; dev_rdata = rdat;
        @(negedge clk);
        dev_done = 1'b0;
        rd(ch, 3'd3, v);
        chk(v[0] === 1'b0, {tag, " R9 start cleared"}, v, 32'd0);
        rd(ch, 3'd0, v);
        chk(v[3] === 1'b1, {tag, " R9 done status"}, v, 32'h8);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, old;
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int ch = 0; ch < 3; ch++) begin
            for (int r = 0; r < 5; r++) begin
                rd(ch, 3'(r), v);
                chk(v === 32'd0, "R1 register zero", v, 32'd0);
            end
            csr_m[ch] = '0;
        end
        chk(cpu_irq === 1'b0 && dev_start === 1'b0, "R1 outputs low", {cpu_irq, dev_start}, 32'd0);

        // R2 plain registers
        wr(1, 3'd1, 32'hDEAD_BEEC); rd(1, 3'd1, v); chk(v === 32'hDEAD_BEEC, "R2 address", v, 32'hDEAD_BEEC);
        wr(2, 3'd2, 32'h0000_0040); rd(2, 3'd2, v); chk(v === 32'h40, "R2 length", v, 32'h40);
        wr(0, 3'd4, 32'h1357_9BDF); rd(0, 3'd4, v); chk(v === 32'h1357_9BDF, "R2 data", v, 32'h1357_9BDF);
        rd(3, 3'd0, v); chk(v === 32'd0, "R2 absent channel", v, 32'd0);

        // R11 attach on all channels, sets statuses for the random phase
        @(negedge clk); ext_attach = 3'b111; ext_dev_irq = 3'b111;
        @(negedge clk); ext_attach = '0; ext_dev_irq = '0;
        for (int ch = 0; ch < 3; ch++) begin
            csr_m[ch] = csr_m[ch] | 32'h1802;
            rd(ch, 3'd0, v);
            chk(v === csr_m[ch], "R11 R13 attach and device status", v, csr_m[ch]);
        end

        // random status/control writes with colliding device events: R3 R4 R5 R13
        for (int it = 0; it < 60; it++) begin
            int ch;
            logic [31:0] d;
            logic [2:0] ev;
            ch = int'($urandom_range(0, 2));
            d  = $urandom() & 32'hFFFF_F0FF;
            if (it < 10) d[11] = 1'b0;
            ev = 3'($urandom_range(0, 7));
            @(negedge clk);
            reg_wr = 1'b1; reg_waddr = {2'(ch), 3'd0}; reg_wdata = d; ext_dev_irq = ev;
            @(negedge clk);
            reg_wr = 1'b0; ext_dev_irq = '0;
            csr_m[ch] = csr_after(csr_m[ch], d);
            for (int k = 0; k < 3; k++) if (ev[k]) csr_m[k][1] = 1'b1;
            rd(ch, 3'd0, v);
            chk(v === csr_m[ch], "R3 R4 status write", v, csr_m[ch]);
            chk(cpu_irq === (irq_of(csr_m[0]) | irq_of(csr_m[1]) | irq_of(csr_m[2])),
                "R5 merged irq", 32'(cpu_irq), 32'(irq_of(csr_m[0]) | irq_of(csr_m[1]) | irq_of(csr_m[2])));
        end

        // clear everything and deselect
        for (int ch = 0; ch < 3; ch++) begin
            wr(ch, 3'd0, ST);
            csr_m[ch] = csr_after(csr_m[ch], ST);
        end
        chk(cpu_irq === 1'b0, "R5 irq cleared", 32'(cpu_irq), 32'd0);

        // R6 priority decode on channel 2
        wr(2, 3'd0, 32'h0000_0300); xfer(2, 32'h0000_0001, 32'h0, 2'd1, 1'b1, "R6 cs 110");
        wr(2, 3'd0, 32'h0000_0388); xfer(2, 32'h0000_0011, 32'h0, 2'd0, 1'b1, "R6 cs 111");
        wr(2, 3'd0, 32'h0000_0208); xfer(2, 32'h0000_0021, 32'h0, 2'd2, 1'b1, "R6 cs 100");

        // R7 no chip select
        wr(1, 3'd0, 32'h0000_0000);
        wr(1, 3'd3, 32'h0000_0001);
        chk(dev_start === 1'b0, "R7 no launch", 32'(dev_start), 32'd0);
        @(negedge clk);
        chk(dev_start === 1'b0, "R7 no launch later", 32'(dev_start), 32'd0);
        rd(1, 3'd3, v); chk(v === 32'd0, "R7 start bit zero", v, 32'd0);

        // R9 immediate read loads data; DMA read leaves it
        wr(0, 3'd0, 32'h0000_0080);
        xfer(0, 32'h0000_0031, 32'hA5A5_1234, 2'd0, 1'b1, "R9 imm read");
        rd(0, 3'd4, v); chk(v === 32'hA5A5_1234, "R9 data loaded", v, 32'hA5A5_1234);
        xfer(0, 32'h0000_0003, 32'h5555_0000, 2'd0, 1'b1, "R9 dma read");
        rd(0, 3'd4, v); chk(v === 32'hA5A5_1234, "R9 data kept on dma", v, 32'hA5A5_1234);

        // R10 command phase sequence
        wr(0, 3'd0, 32'h0000_0088);
        xfer(0, 32'h0000_0035, 32'h0, 2'd0, 1'b1, "R10 first write");
        xfer(0, 32'h0000_0035, 32'h0, 2'd0, 1'b0, "R10 second write");
        wr(0, 3'd0, 32'h0000_0088);
        xfer(0, 32'h0000_0005, 32'h0, 2'd0, 1'b1, "R10 rearmed");

        // R12 start while busy, and R4 done colliding with a clear of bit 3
        wr(1, 3'd0, 32'h0000_0080);
        wr(0, 3'd3, 32'h0000_0001);
        chk(dev_start === 1'b1, "R12 first launch", 32'(dev_start), 32'd1);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = {2'd1, 3'd3}; reg_wdata = 32'h0000_0001;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(dev_start === 1'b0, "R12 no second launch", 32'(dev_start), 32'd0);
        rd(1, 3'd3, v); chk(v[0] === 1'b0, "R12 busy start bit zero", v, 32'd0);
        rd(0, 3'd0, old); chk(old[3] === 1'b1, "R4 setup status", old, 32'h8);
        reg_wr = 1'b1; reg_waddr = {2'd0, 3'd0}; reg_wdata = 32'h0000_0088; dev_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; dev_done = 1'b0;
        rd(0, 3'd0, v); chk(v[3] === 1'b1, "R4 done wins over clear", v, 32'h8);
        chk(dev_start === 1'b0, "R12 idle after", 32'(dev_start), 32'd0);

        // R11 detach / attach, R4 attach colliding with clear of bit 11
        wr(0, 3'd0, 32'h0000_0008);
        wr(2, 3'd0, 32'h0000_0400 | ST);
        @(negedge clk); ext_detach = 3'b100;
        @(negedge clk); ext_detach = '0;
        rd(2, 3'd0, v);
        chk(v[12] === 1'b0 && v[11] === 1'b1, "R11 detach", v, 32'h0000_0C00);
        chk(cpu_irq === 1'b1, "R5 attach irq", 32'(cpu_irq), 32'd1);
        reg_wr = 1'b1; reg_waddr = {2'd2, 3'd0}; reg_wdata = 32'h0000_0C00; ext_attach = 3'b100;
        @(negedge clk);
        reg_wr = 1'b0; ext_attach = '0;
        rd(2, 3'd0, v);
        chk(v[12] === 1'b1 && v[11] === 1'b1, "R4 R11 attach wins over clear", v, 32'h0000_1C00);

        // R13 device interrupt
        wr(1, 3'd0, 32'h0000_0001);
        @(negedge clk); ext_dev_irq = 3'b010;
        @(negedge clk); ext_dev_irq = '0;
        rd(1, 3'd0, v); chk(v[1] === 1'b1, "R13 device status", v, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule